// File: doc/BRIEF.md
# Nibble Port Transfer and Modify Unit

This unit carries out the port-oriented instructions of a small 4-bit controller core. It owns the output latches of sixteen nibble-wide ports, takes instruction bytes one at a time from the fetch side, and reads the accumulator, the E register, the low data-pointer nibble and the addressed memory nibble as plain inputs. It does not write those registers itself. Instead it returns one-cycle write strobes with data for the accumulator, E, memory and the zero flag, and the core applies them.

Port reads that load a register sample the external pin values. Bit set, bit clear, AND and OR read the port's own output latch, so bits that the instruction does not name keep their latched state. Any byte with upper nibble `1100` opens a two-byte form. The second byte then picks one of the following: a direct-addressed transfer, the paired E/AC transfer on ports 4 and 5, or an AND/OR of a port with the immediate carried in the first byte.

Top module: `pio_exec`

## Requirements
- R1: While reset is held and after its release, every port latch reads 0 and no write strobe or illegal pulse is asserted.
- R2: One-byte `0x20` loads AC from pin group 0, `0x26` loads AC from pin group DPL, and `1100_0110` followed by `1111_nnnn` loads AC from pin group n. Each asserts the AC strobe and the ZF strobe, with ZF = 1 exactly when the loaded nibble is 0.
- R3: `0x19` raises the memory write strobe carrying pin group DPL and leaves the ZF strobe low.
- R4: `0x25` writes AC into latch DPL, `0x1A` writes the memory nibble into latch DPL, and `1100_0111` followed by `1111_nnnn` writes AC into latch n. None of them strobes ZF.
- R5: After prefix `1100_1101`, second byte `1111_0100` loads E from pin group 4 and AC from pin group 5, and `1111_0101` writes E to latch 4 and AC to latch 5. Neither strobes ZF.
- R6: `0000_10tt` sets bit tt and `0010_10tt` clears bit tt of latch DPL. The other latch bits are kept, the pins are not consulted, and ZF is not strobed.
- R7: After prefix `1100_iiii`, second byte `0101_pppp` writes latch p AND i back to latch p, and `0100_pppp` writes latch p OR i. Both strobe ZF with 1 exactly when the result is 0.
- R8: Every `1100_xxxx` byte is held as a pending prefix for as many idle cycles as pass. The upper nibble of the next byte alone decides between the AND/OR forms and the `1111` forms.
- R9: A first byte outside the listed encodings, or a second byte that matches no form for its prefix, gives a one-cycle illegal pulse, leaves every latch unchanged, asserts no strobe and drops the pending prefix.
- R10: Results appear on the cycle after the completing byte is accepted and last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | Instruction byte present this cycle |
| instr_byte_i | input | 8 | Instruction byte |
| ac_i | input | DW | Current accumulator |
| e_i | input | DW | Current E register |
| dpl_i | input | ADDR_W | Low data-pointer nibble (port index) |
| mem_i | input | DW | Memory nibble at HL |
| port_pins_i | input | NPORTS*DW | Pin values of all ports, port k at bits k*DW |
| port_o | output | NPORTS*DW | Output latches of all ports, port k at bits k*DW |
| ac_we_o | output | 1 | Accumulator write strobe |
| ac_wdata_o | output | DW | Accumulator write data |
| e_we_o | output | 1 | E register write strobe |
| e_wdata_o | output | DW | E register write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | DW | Memory write data |
| zf_we_o | output | 1 | Zero flag write strobe |
| zf_o | output | 1 | Zero flag value |
| illegal_o | output | 1 | Unrecognised instruction pulse |

## Verification
The bench builds the unit with its defaults, DW = 4 and ADDR_W = 4. Every port index that DPL or a second-byte field can name is therefore a real port, and the four bit positions of the set and clear forms cover the whole nibble. The AND/OR prefixes whose immediates coincide with the direct-transfer and paired-transfer prefixes (`0110`, `0111`, `1101`) can all be issued, so the second-byte disambiguation is exercised against a real latch. Pin values are chosen to differ from the latch contents, which separates pin reads from latch reads.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;

    typedef enum logic [3:0] {
        OP_ILLEGAL,
        OP_PREFIX,
        OP_IN_P0,
        OP_IN_IND,
        OP_IN_MEM,
        OP_OUT_IND,
        OP_OUT_MEM,
        OP_IN_DIR,
        OP_OUT_DIR,
        OP_IN_PAIR,
        OP_OUT_PAIR,
        OP_SETB,
        OP_CLRB,
        OP_ANDI,
        OP_ORI
    } op_e;

endpackage

// File: rtl/pio_decode.sv
`timescale 1ns/1ps
module pio_decode
    import pio_pkg::*;
#(
    parameter int DW     = 4,
    parameter int ADDR_W = 4
) (
    input  logic              pend_i,
    input  logic [3:0]        pend_low_i,
    input  logic [7:0]        byte_i,
    input  logic [ADDR_W-1:0] dpl_i,
    output op_e               op_o,
    output logic [ADDR_W-1:0] idx_o,
    output logic [DW-1:0]     imm_o,
    output logic [1:0]        bsel_o
);

    always_comb begin
        op_o   = OP_ILLEGAL;
        idx_o  = dpl_i;
        imm_o  = '0;
        bsel_o = byte_i[1:0];
        if (!pend_i) begin
            casez (byte_i)
                8'b0010_0000: begin op_o = OP_IN_P0; idx_o = '0; end
                8'b0010_0110: op_o = OP_IN_IND;
                8'b0001_1001: op_o = OP_IN_MEM;
                8'b0010_0101: op_o = OP_OUT_IND;
                8'b0001_1010: op_o = OP_OUT_MEM;
                8'b0000_10??: op_o = OP_SETB;
                8'b0010_10??: op_o = OP_CLRB;
                8'b1100_????: op_o = OP_PREFIX;
                default:      op_o = OP_ILLEGAL;
            endcase
        end else begin
            idx_o = ADDR_W'(byte_i[3:0]);
            imm_o = DW'(pend_low_i);
            case (byte_i[7:4])
                4'b0101: op_o = OP_ANDI;
                4'b0100: op_o = OP_ORI;
                4'b1111: begin
                    if (pend_low_i == 4'b0110)
                        op_o = OP_IN_DIR;
                    else if (pend_low_i == 4'b0111)
                        op_o = OP_OUT_DIR;
                    else if (pend_low_i == 4'b1101 && byte_i[3:0] == 4'b0100)
                        op_o = OP_IN_PAIR;
                    else if (pend_low_i == 4'b1101 && byte_i[3:0] == 4'b0101)
                        op_o = OP_OUT_PAIR;
                    else
                        op_o = OP_ILLEGAL;
                end
                default: op_o = OP_ILLEGAL;
            endcase
        end
    end

endmodule

// File: rtl/pio_rmw.sv
`timescale 1ns/1ps
module pio_rmw
    import pio_pkg::*;
#(
    parameter int DW = 4
) (
    input  op_e           op_i,
    input  logic [DW-1:0] cur_i,
    input  logic [DW-1:0] imm_i,
    input  logic [1:0]    bsel_i,
    output logic [DW-1:0] res_o
);

    logic [DW-1:0] mask;

    always_comb begin
        mask = DW'(1) << bsel_i;
        case (op_i)
            OP_SETB: res_o = cur_i | mask;
            OP_CLRB: res_o = cur_i & ~mask;
            OP_ANDI: res_o = cur_i & imm_i;
            OP_ORI:  res_o = cur_i | imm_i;
            default: res_o = cur_i;
        endcase
    end

endmodule

// File: rtl/pio_exec.sv
`timescale 1ns/1ps
module pio_exec
    import pio_pkg::*;
#(
    parameter int DW     = 4,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     instr_valid_i,
    input  logic [7:0]               instr_byte_i,
    input  logic [DW-1:0]            ac_i,
    input  logic [DW-1:0]            e_i,
    input  logic [ADDR_W-1:0]        dpl_i,
    input  logic [DW-1:0]            mem_i,
    input  logic [(1<<ADDR_W)*DW-1:0] port_pins_i,
    output logic [(1<<ADDR_W)*DW-1:0] port_o,
    output logic                     ac_we_o,
    output logic [DW-1:0]            ac_wdata_o,
    output logic                     e_we_o,
    output logic [DW-1:0]            e_wdata_o,
    output logic                     mem_we_o,
    output logic [DW-1:0]            mem_wdata_o,
    output logic                     zf_we_o,
    output logic                     zf_o,
    output logic                     illegal_o
);

    localparam int NPORTS = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] PAIR_LO = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] PAIR_HI = ADDR_W'(5);

    typedef struct packed {
        logic                         pend;
        logic [3:0]                   pend_low;
        logic [NPORTS-1:0][DW-1:0]    ports;
        logic                         ac_we;
        logic [DW-1:0]                ac_val;
        logic                         e_we;
        logic [DW-1:0]                e_val;
        logic                         mem_we;
        logic [DW-1:0]                mem_val;
        logic                         zf_we;
        logic                         zf_val;
        logic                         illegal;
    } state_t;

    state_t st_d, st_q;

    logic [DW-1:0]     pins_w [NPORTS];
    op_e               op_w;
    logic [ADDR_W-1:0] idx_w;
    logic [DW-1:0]     imm_w;
    logic [1:0]        bsel_w;
    logic [DW-1:0]     rmw_res_w;

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        assign pins_w[g]            = port_pins_i[g*DW +: DW];
        assign port_o[g*DW +: DW]   = st_q.ports[g];
    end

    pio_decode #(.DW(DW), .ADDR_W(ADDR_W)) u_decode (
        .pend_i     (st_q.pend),
        .pend_low_i (st_q.pend_low),
        .byte_i     (instr_byte_i),
        .dpl_i      (dpl_i),
        .op_o       (op_w),
        .idx_o      (idx_w),
        .imm_o      (imm_w),
        .bsel_o     (bsel_w)
    );

    pio_rmw #(.DW(DW)) u_rmw (
        .op_i   (op_w),
        .cur_i  (st_q.ports[idx_w]),
        .imm_i  (imm_w),
        .bsel_i (bsel_w),
        .res_o  (rmw_res_w)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ac_we   = 1'b0;
        st_d.e_we    = 1'b0;
        st_d.mem_we  = 1'b0;
        st_d.zf_we   = 1'b0;
        st_d.illegal = 1'b0;
        if (instr_valid_i) begin
            st_d.pend = 1'b0;
            case (op_w)
                OP_PREFIX: begin
                    st_d.pend     = 1'b1;
                    st_d.pend_low = instr_byte_i[3:0];
                end
                OP_IN_P0, OP_IN_IND, OP_IN_DIR: begin
                    st_d.ac_we  = 1'b1;
                    st_d.ac_val = pins_w[idx_w];
                    st_d.zf_we  = 1'b1;
                    st_d.zf_val = (pins_w[idx_w] == '0);
                end
                OP_IN_MEM: begin
                    st_d.mem_we  = 1'b1;
                    st_d.mem_val = pins_w[idx_w];
                end
                OP_OUT_IND, OP_OUT_DIR: st_d.ports[idx_w] = ac_i;
                OP_OUT_MEM:             st_d.ports[idx_w] = mem_i;
                OP_IN_PAIR: begin
                    st_d.e_we   = 1'b1;
                    st_d.e_val  = pins_w[PAIR_LO];
                    st_d.ac_we  = 1'b1;
                    st_d.ac_val = pins_w[PAIR_HI];
                end
                OP_OUT_PAIR: begin
                    st_d.ports[PAIR_LO] = e_i;
                    st_d.ports[PAIR_HI] = ac_i;
                end
                OP_SETB, OP_CLRB: st_d.ports[idx_w] = rmw_res_w;
                OP_ANDI, OP_ORI: begin
                    st_d.ports[idx_w] = rmw_res_w;
                    st_d.zf_we        = 1'b1;
                    st_d.zf_val       = (rmw_res_w == '0);
                end
                default: st_d.illegal = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ac_we_o     = st_q.ac_we;
    assign ac_wdata_o  = st_q.ac_val;
    assign e_we_o      = st_q.e_we;
    assign e_wdata_o   = st_q.e_val;
    assign mem_we_o    = st_q.mem_we;
    assign mem_wdata_o = st_q.mem_val;
    assign zf_we_o     = st_q.zf_we;
    assign zf_o        = st_q.zf_val;
    assign illegal_o   = st_q.illegal;

    // R9: an illegal pulse leaves every latch as it was
    a_r9_illegal_keeps_ports: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> port_o == $past(port_o));

    // R9: no strobe accompanies an illegal pulse
    a_r9_illegal_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !(ac_we_o || e_we_o || mem_we_o || zf_we_o));

    // R2: a flag update alongside an AC load reflects the loaded nibble
    a_r2_zero_tracks_ac: assert property (@(posedge clk) disable iff (!rst_n)
        (zf_we_o && ac_we_o) |-> (zf_o == (ac_wdata_o == '0)));

    // R5: E is only loaded together with AC, never with a flag update
    a_r5_pair_load: assert property (@(posedge clk) disable iff (!rst_n)
        e_we_o |-> (ac_we_o && !zf_we_o));

    // R3: a memory write stands alone
    a_r3_mem_alone: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !(ac_we_o || e_we_o || zf_we_o));

    // R8: the byte after a pending prefix always consumes it
    a_r8_prefix_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && instr_valid_i) |=> !st_q.pend);

endmodule

// File: tb/pio_exec_tb_top.sv
`timescale 1ns/1ps
module pio_exec_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid_i = 1'b0;
    logic [7:0]  instr_byte_i = '0;
    logic [3:0]  ac_i = '0;
    logic [3:0]  e_i = '0;
    logic [3:0]  dpl_i = '0;
    logic [3:0]  mem_i = '0;
    logic [63:0] pins = '0;
    logic [63:0] port_o;
    logic        ac_we_o, e_we_o, mem_we_o, zf_we_o, zf_o, illegal_o;
    logic [3:0]  ac_wdata_o, e_wdata_o, mem_wdata_o;

    always #2.5 clk = ~clk;

    pio_exec dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i), .instr_byte_i(instr_byte_i),
        .ac_i(ac_i), .e_i(e_i), .dpl_i(dpl_i), .mem_i(mem_i), .port_pins_i(pins),
        .port_o(port_o), .ac_we_o(ac_we_o), .ac_wdata_o(ac_wdata_o), .e_we_o(e_we_o),
        .e_wdata_o(e_wdata_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
        .zf_we_o(zf_we_o), .zf_o(zf_o), .illegal_o(illegal_o)
    );

    typedef struct {
        logic       ac_we;  logic [3:0] ac;
        logic       e_we;   logic [3:0] e;
        logic       mem_we; logic [3:0] mem;
        logic       zf_we;  logic       zf;
        logic       ill;
        logic [63:0] ports;
        int          due;
        string       tag;
    } exp_t;

    exp_t       sb[$];
    logic [3:0] mdl [16];
    int         cyc = 0;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [3:0] pin(input int k);
        return pins[k*4 +: 4];
    endfunction

    function automatic logic [63:0] mdl_flat();
        logic [63:0] v;
        for (int k = 0; k < 16; k++) v[k*4 +: 4] = mdl[k];
        return v;
    endfunction

    function automatic exp_t blank(input string tag);
        exp_t e;
        e.ac_we = 0; e.ac = 0; e.e_we = 0; e.e = 0; e.mem_we = 0; e.mem = 0;
        e.zf_we = 0; e.zf = 0; e.ill = 0; e.ports = '0; e.due = 0; e.tag = tag;
        return e;
    endfunction

    // driver: called at a falling edge, returns at the next one
    task automatic issue(input logic [7:0] b, input exp_t e);
        instr_valid_i = 1'b1;
        instr_byte_i  = b;
        e.ports = mdl_flat();
        e.due   = cyc + 1;
        sb.push_back(e);
        @(negedge clk);
        instr_valid_i = 1'b0;
    endtask

    // monitor: compares outputs against due scoreboard items
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            logic [81:0] act, exv;
            e = sb.pop_front();
            act = {ac_we_o, e.ac_we ? ac_wdata_o : 4'h0, e_we_o, e.e_we ? e_wdata_o : 4'h0,
                   mem_we_o, e.mem_we ? mem_wdata_o : 4'h0, zf_we_o, e.zf_we ? zf_o : 1'b0,
                   illegal_o, port_o};
            exv = {e.ac_we, e.ac, e.e_we, e.e, e.mem_we, e.mem, e.zf_we, e.zf, e.ill, e.ports};
            n_chk++;
            if (act !== exv) begin
                n_bad++;
                $display("FAIL %s actual=%h expected=%h", e.tag, act, exv);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [81:0] a, input logic [81:0] x);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, a, x);
        end
    endtask

    task automatic in_ac(input logic [7:0] b, input int k, input string tag);
        exp_t e = blank(tag);
        e.ac_we = 1; e.ac = pin(k); e.zf_we = 1; e.zf = (pin(k) == 4'h0);
        issue(b, e);
    endtask

    task automatic rmw(input logic [3:0] imm, input logic [3:0] sec_hi, input int k);
        exp_t e = blank("R7");
        issue({4'b1100, imm}, blank("R8"));
        mdl[k] = (sec_hi == 4'b0101) ? (mdl[k] & imm) : (mdl[k] | imm);
        e.zf_we = 1; e.zf = (mdl[k] == 4'h0);
        issue({sec_hi, 4'(k)}, e);
    endtask

    initial begin
        exp_t e;
        for (int k = 0; k < 16; k++) begin
            mdl[k] = 4'h0;
            pins[k*4 +: 4] = 4'((k * 3 + 1) & 15);
        end
        pins[3:0] = 4'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(port_o == '0 && !ac_we_o && !e_we_o && !mem_we_o && !zf_we_o && !illegal_o,
            "R1", {13'd0, ac_we_o, e_we_o, mem_we_o, zf_we_o, illegal_o, port_o}, 82'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(port_o == '0 && !illegal_o, "R1", {18'd0, port_o}, 82'd0);

        // R2: load from port 0 (zero, then nonzero)
        in_ac(8'h20, 0, "R2");
        pins[3:0] = 4'h5;
        in_ac(8'h20, 0, "R2");
        // R10: strobe gone one cycle later
        @(negedge clk);
        chk(!ac_we_o && !zf_we_o, "R10", {80'd0, ac_we_o, zf_we_o}, 82'd0);
        // R2: indirect load
        dpl_i = 4'd3;
        in_ac(8'h26, 3, "R2");
        // R3: indirect to memory
        dpl_i = 4'd7;
        e = blank("R3"); e.mem_we = 1; e.mem = pin(7);
        issue(8'h19, e);
        // R4: AC and memory to latches
        dpl_i = 4'd2; ac_i = 4'h9; mdl[2] = 4'h9;
        issue(8'h25, blank("R4"));
        dpl_i = 4'd15; mem_i = 4'h6; mdl[15] = 4'h6;
        issue(8'h1A, blank("R4"));
        // R2 / R8: direct load from port 12
        issue(8'hC6, blank("R8"));
        in_ac(8'hFC, 12, "R2");
        // R4: direct write to port 11
        ac_i = 4'h3;
        issue(8'hC7, blank("R8"));
        mdl[11] = 4'h3;
        issue(8'hFB, blank("R4"));
        // R5: pair load and pair store
        issue(8'hCD, blank("R8"));
        e = blank("R5"); e.e_we = 1; e.e = pin(4); e.ac_we = 1; e.ac = pin(5);
        issue(8'hF4, e);
        e_i = 4'hA; ac_i = 4'h7;
        issue(8'hCD, blank("R8"));
        mdl[4] = 4'hA; mdl[5] = 4'h7;
        issue(8'hF5, blank("R5"));
        // R6: set bit 2 then clear bit 0 of latch 2 (pins differ from latch)
        dpl_i = 4'd2;
        mdl[2] = mdl[2] | 4'h4;
        issue(8'h0A, blank("R6"));
        mdl[2] = mdl[2] & 4'hE;
        issue(8'h28, blank("R6"));
        // R7: AND to zero, then OR
        rmw(4'h0, 4'b0101, 2);
        rmw(4'h5, 4'b0100, 2);
        // R8: AND whose immediate matches the direct-load prefix
        rmw(4'h6, 4'b0101, 11);
        // R9: unknown single bytes
        e = blank("R9"); e.ill = 1;
        issue(8'hFF, e);
        issue(8'h00, e);
        // R9: bad second bytes drop the prefix
        issue(8'hC6, blank("R8"));
        issue(8'hE1, e);
        pins[3:0] = 4'h0;
        in_ac(8'h20, 0, "R9");
        issue(8'hCD, blank("R8"));
        issue(8'hF7, e);
        // R8: prefix held across idle cycles
        issue(8'hC7, blank("R8"));
        repeat (3) @(negedge clk);
        ac_i = 4'hE; mdl[9] = 4'hE;
        issue(8'hF9, blank("R8"));

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R10", 82'(sb.size()), 82'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R10 actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule